// File: doc/BRIEF.md
# Channel Hit Rate Monitor

This block estimates how often one channel's discriminator fires. It keeps two counters side by side. One counts threshold crossings. The other counts microseconds, advanced by a one-cycle tick enable that arrives once per microsecond. Software divides the first by the second to get a rate; that division is not done here. A read strobe copies both counters and a saturation indication into output registers, then starts a fresh interval from zero. The copied values are what goes into the event record.

The discriminator input is asynchronous and passes through a synchronizer. A hit is the rising edge of the synchronized level, so a level that stays high counts once. Hits are counted at all times, with no regard to the acquisition's dead time. An optional veto gate rejects afterpulses: after an accepted hit, further edges are ignored for a programmable number of clocks. When either counter reaches its all-ones value, both stop together, so the pair still gives a valid ratio. All pins are plain control and status signals. There is no streaming interface and no back-pressure: the snapshot registers simply hold their value until the next read strobe.

Top module: `hrm_rate_monitor`

## Requirements
- R1: The hit counter (HIT_W bits, default 16) increases by one for each 0-to-1 transition of the synchronized `disc_in`. A level held high for many cycles counts as exactly one hit.
- R2: The time counter (TIME_W bits, default 24) increases by one in every cycle where `tick_us` is 1, and in no other cycle.
- R3: In a cycle where `rd_stb` is 1, both counters restart. A hit or tick in that same cycle becomes the first count of the new interval (value 1); otherwise the counter starts at 0. The restart also clears `live_sat`.
- R4: Once either counter equals its all-ones value, neither counter changes until the next read strobe, and `live_sat` is 1.
- R5: From the cycle after a read strobe, `hit_snap`, `time_snap` and `snap_sat` show the hit count, time count and `live_sat` as they stood in the strobe cycle, excluding any hit or tick of that cycle. They hold those values until the next strobe.
- R6: With `veto_len` = L > 0, an accepted hit opens a gate covering the next L clock cycles. Edges inside the gate are dropped, and they do not extend it. An edge L+1 cycles after the accepted hit is counted.
- R7: With `veto_len` = 0, every edge is counted, including edges two cycles apart.
- R8: After reset, `hit_snap`, `time_snap`, `snap_sat` and `live_sat` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_in | input | 1 | Discriminator output, asynchronous to clk |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| rd_stb | input | 1 | Snapshot and restart strobe |
| veto_len | input | VETO_W | Afterpulse gate length in clocks; 0 turns the gate off |
| hit_snap | output | HIT_W | Hit count captured at the last read |
| time_snap | output | TIME_W | Microsecond count captured at the last read |
| snap_sat | output | 1 | Saturation state captured at the last read |
| live_sat | output | 1 | The current interval is frozen by saturation |

## Verification
Hit trains are driven with spacings just above and at the veto length. This shows whether the gate covers exactly L cycles, and whether it wrongly restarts on the edges it drops. Separate runs show that single-cycle pulses, two-cycle spacing with the veto off, and one long high level are told apart, the long level counting once. Overflow is driven separately in each counter, to show that either one freezes the other. Hits and ticks placed in the read cycle itself show which interval they belong to.

// File: rtl/hrm_pkg.sv
package hrm_pkg;

  // Operation applied to a counter in a given cycle
  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_INC,
    CNT_CLR,
    CNT_SET1
  } cnt_op_e;

  // Restart wins over everything; the event of the restart cycle seeds the new interval
  function automatic cnt_op_e pick_op(input logic restart, input logic frozen, input logic ev);
    if (restart) return ev ? CNT_SET1 : CNT_CLR;
    if (frozen || !ev) return CNT_HOLD;
    return CNT_INC;
  endfunction

endpackage

// File: rtl/hrm_edge_sync.sv
module hrm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/hrm_veto_gate.sv
module hrm_veto_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         raw_hit,
  input  logic [W-1:0] gate_len,
  output logic         hit_ok,
  output logic         busy
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] remain_q;

  assign busy   = (remain_q != '0);
  assign hit_ok = raw_hit & ~busy;

  // Not retriggerable: only an accepted hit loads the gate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain_q <= '0;
    else if (hit_ok) remain_q <= gate_len;
    else if (busy)   remain_q <= remain_q - ONE;
  end
endmodule

// File: rtl/hrm_sat_counter.sv
module hrm_sat_counter
  import hrm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_op_e      op,
  output logic [W-1:0] value,
  output logic         full
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else begin
      case (op)
        CNT_INC:  value <= value + ONE;
        CNT_CLR:  value <= '0;
        CNT_SET1: value <= ONE;
        default:  value <= value;
      endcase
    end
  end

  assign full = (value == '1);
endmodule

// File: rtl/hrm_rate_monitor.sv
module hrm_rate_monitor
  import hrm_pkg::*;
#(
  parameter int HIT_W       = 16,
  parameter int TIME_W      = 24,
  parameter int VETO_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disc_in,
  input  logic              tick_us,
  input  logic              rd_stb,
  input  logic [VETO_W-1:0] veto_len,
  output logic [HIT_W-1:0]  hit_snap,
  output logic [TIME_W-1:0] time_snap,
  output logic              snap_sat,
  output logic              live_sat
);
  logic              hit_raw;
  logic              hit_acc;
  logic              veto_busy;
  logic [HIT_W-1:0]  hit_cnt;
  logic [TIME_W-1:0] time_cnt;
  logic              hit_full;
  logic              time_full;
  logic              sat_now;
  cnt_op_e           hit_op;
  cnt_op_e           time_op;

  hrm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(disc_in), .rise_o(hit_raw)
  );

  hrm_veto_gate #(.W(VETO_W)) u_veto (
    .clk(clk), .rst_n(rst_n), .raw_hit(hit_raw), .gate_len(veto_len),
    .hit_ok(hit_acc), .busy(veto_busy)
  );

  // One counter at all-ones freezes both
  assign sat_now = hit_full | time_full;
  assign hit_op  = pick_op(rd_stb, sat_now, hit_acc);
  assign time_op = pick_op(rd_stb, sat_now, tick_us);

  hrm_sat_counter #(.W(HIT_W)) u_hits (
    .clk(clk), .rst_n(rst_n), .op(hit_op), .value(hit_cnt), .full(hit_full)
  );

  hrm_sat_counter #(.W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_n), .op(time_op), .value(time_cnt), .full(time_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_snap  <= '0;
      time_snap <= '0;
      snap_sat  <= 1'b0;
    end else if (rd_stb) begin
      hit_snap  <= hit_cnt;
      time_snap <= time_cnt;
      snap_sat  <= sat_now;
    end
  end

  assign live_sat = sat_now;
endmodule

// File: rtl/hrm_rate_monitor_chk.sv
module hrm_rate_monitor_chk #(
  parameter int HIT_W  = 16,
  parameter int TIME_W = 24,
  parameter int VETO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_us,
  input logic              rd_stb,
  input logic [VETO_W-1:0] veto_len,
  input logic [HIT_W-1:0]  hit_cnt,
  input logic [TIME_W-1:0] time_cnt,
  input logic              hit_acc,
  input logic              veto_busy,
  input logic [HIT_W-1:0]  hit_snap,
  input logic [TIME_W-1:0] time_snap,
  input logic              snap_sat,
  input logic              live_sat
);
  localparam logic [HIT_W-1:0]  HIT_ONE  = {{(HIT_W-1){1'b0}}, 1'b1};
  localparam logic [TIME_W-1:0] TIME_ONE = {{(TIME_W-1){1'b0}}, 1'b1};

  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (hit_cnt == $past(hit_cnt) || hit_cnt == $past(hit_cnt) + HIT_ONE)); // R1

  AST_TIME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !tick_us) |=> $stable(time_cnt)); // R2

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (hit_cnt <= HIT_ONE && time_cnt <= TIME_ONE && !live_sat)); // R3

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (live_sat && !rd_stb) |=> ($stable(hit_cnt) && $stable(time_cnt) && live_sat)); // R4

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (hit_snap == $past(hit_cnt) && time_snap == $past(time_cnt)
                && snap_sat == $past(live_sat))); // R5

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ($stable(hit_snap) && $stable(time_snap) && $stable(snap_sat))); // R5

  AST_GATE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_acc && veto_len != '0) |=> veto_busy); // R6

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (veto_len == '0 && $stable(veto_len)) |-> !veto_busy || $past(veto_len) != '0 || $past(veto_busy)); // R7
endmodule

bind hrm_rate_monitor hrm_rate_monitor_chk #(
  .HIT_W(HIT_W), .TIME_W(TIME_W), .VETO_W(VETO_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .rd_stb(rd_stb), .veto_len(veto_len),
  .hit_cnt(hit_cnt), .time_cnt(time_cnt), .hit_acc(hit_acc), .veto_busy(veto_busy),
  .hit_snap(hit_snap), .time_snap(time_snap), .snap_sat(snap_sat), .live_sat(live_sat)
);

// File: tb/hrm_rate_monitor_tb_top.sv
module hrm_rate_monitor_tb_top;
  localparam int HIT_W  = 6;
  localparam int TIME_W = 8;
  localparam int VETO_W = 8;
  localparam int HIT_MAX  = (1 << HIT_W) - 1;
  localparam int TIME_MAX = (1 << TIME_W) - 1;

  // pulses, period, veto_len, ticks, expected hits, expected time
  localparam int NVEC = 7;
  localparam int VEC [NVEC][6] = '{
    '{5, 4, 0, 3, 5, 3},   // R1 R2 R7 plain train
    '{6, 6, 5, 0, 6, 0},   // R6 spacing L+1 all counted
    '{6, 5, 5, 0, 3, 0},   // R6 spacing L, every other dropped
    '{4, 2, 0, 10, 4, 10}, // R7 two-cycle spacing, veto off
    '{7, 3, 1, 0, 7, 0},   // R6 short gate
    '{7, 3, 3, 0, 4, 0},   // R6 no retrigger from dropped edges
    '{0, 2, 0, 0, 0, 0}    // R1 R2 idle interval
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disc_in = 1'b0;
  logic tick_us = 1'b0;
  logic rd_stb = 1'b0;
  logic [VETO_W-1:0] veto_len = '0;
  logic [HIT_W-1:0]  hit_snap;
  logic [TIME_W-1:0] time_snap;
  logic snap_sat;
  logic live_sat;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  hrm_rate_monitor #(.HIT_W(HIT_W), .TIME_W(TIME_W), .VETO_W(VETO_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .tick_us(tick_us), .rd_stb(rd_stb),
    .veto_len(veto_len), .hit_snap(hit_snap), .time_snap(time_snap),
    .snap_sat(snap_sat), .live_sat(live_sat)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      disc_in = 1'b1; @(negedge clk);
      disc_in = 1'b0; idle(period - 1);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1'b1; @(negedge clk);
      tick_us = 1'b0; @(negedge clk);
    end
  endtask

  task automatic do_read();
    rd_stb = 1'b1; @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic run_all();
    idle(3);
    check("R8 hit_snap", int'(hit_snap), 0);
    check("R8 time_snap", int'(time_snap), 0);
    check("R8 snap_sat", int'(snap_sat), 0);
    check("R8 live_sat", int'(live_sat), 0);
    rst_n = 1'b1;
    idle(2);
    do_read();

    for (int v = 0; v < NVEC; v++) begin
      veto_len = VEC[v][2][VETO_W-1:0];
      pulses(VEC[v][0], VEC[v][1]);
      ticks(VEC[v][3]);
      idle(12);
      do_read();
      check($sformatf("R1/R6/R7 vec%0d hits", v), int'(hit_snap), VEC[v][4]);
      check($sformatf("R2 vec%0d time", v), int'(time_snap), VEC[v][5]);
    end
    veto_len = '0;

    // R1: long level counts once
    disc_in = 1'b1; idle(20); disc_in = 1'b0; idle(5);
    do_read();
    check("R1 held level", int'(hit_snap), 1);

    // R5: snapshot holds while new activity accrues
    pulses(3, 3); ticks(2); idle(5);
    check("R5 snap hold hits", int'(hit_snap), 1);
    check("R5 snap hold time", int'(time_snap), 0);
    do_read();
    check("R5 snap new hits", int'(hit_snap), 3);
    check("R5 snap new time", int'(time_snap), 2);

    // R3: hit and tick in the read cycle start the new interval
    pulses(2, 4); idle(4);
    disc_in = 1'b1; @(negedge clk); @(negedge clk);
    rd_stb = 1'b1; tick_us = 1'b1; @(negedge clk);
    rd_stb = 1'b0; tick_us = 1'b0; disc_in = 1'b0;
    check("R5 read excludes same-cycle hit", int'(hit_snap), 2);
    idle(6);
    do_read();
    check("R3 same-cycle hit carried", int'(hit_snap), 1);
    check("R3 same-cycle tick carried", int'(time_snap), 1);

    // R4: hit counter saturation freezes time too
    ticks(2); pulses(HIT_MAX + 7, 2); ticks(5); idle(5);
    check("R4 live_sat on hit overflow", int'(live_sat), 1);
    do_read();
    check("R4 hits frozen at max", int'(hit_snap), HIT_MAX);
    check("R4 time frozen", int'(time_snap), 2);
    check("R5 snap_sat captured", int'(snap_sat), 1);
    check("R3 live_sat cleared by read", int'(live_sat), 0);

    // R4: time counter saturation freezes hits
    ticks(TIME_MAX + 5); pulses(3, 3); idle(5);
    check("R4 live_sat on time overflow", int'(live_sat), 1);
    do_read();
    check("R4 time frozen at max", int'(time_snap), TIME_MAX);
    check("R4 hits frozen by time", int'(hit_snap), 0);
    idle(2);
    do_read();
    check("R3 restart after saturation", int'(snap_sat), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule